// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This controller sits between a clocked user port and an external asynchronous static RAM of 131,072 words by 16 bits. The user side sends one transfer at a time: a read of a whole word, or a write in which a two-bit mask picks the byte lanes to update. The handshake is a request/ready pair. A request is taken only while ready is high. Ready stays low until the memory cycle is over. Read data comes back with a valid pulse that lasts one cycle.

On the memory side the controller drives a 17-bit address and five active-low strobes: chip select, output enable, write enable, and one strobe for each byte lane. It also drives the data bus, split into an output value, an output-enable and an input value. The length of each phase is set by two parameters: the clock period and the speed grade of the memory, in nanoseconds. The phases are the read access, the bus turnaround after write enable falls, the data setup, and the write pulse. Each phase time is divided by the clock period and rounded up, with a minimum of one cycle.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is active, and in idle, all five strobes are high, `mem_dq_oe_o` is low, `ready_o` is high and `rvalid_o` is low.
- R2: A request is accepted only at a clock edge where `req_i` and `ready_o` are both high. A request that arrives while busy is ignored: the memory address does not change, no extra memory cycle takes place and no read data is returned.
- R3: A read holds chip select and output enable low, write enable high and both byte strobes low for ACC cycles. It captures the bus at the end of the last of those cycles. `rdata_o` is then valid with a one-cycle `rvalid_o` pulse, ACC cycles after the accepting edge.
- R4: A write holds write enable low for TA+DAT cycles, which is at least the pulse cycle count PW. Mask bit 0 selects the lower lane (data bits 7:0, strobe `mem_lb_no`). Mask bit 1 selects the upper lane (bits 15:8, strobe `mem_ub_no`). A lane whose bit is 0 keeps its old contents. With mask 00 nothing is written. The address does not change while write enable is low.
- R5: Write data is driven and stable for at least SU cycles before write enable rises.
- R6: In the first TA cycles after write enable falls, the controller does not drive the data bus.
- R7: For one cycle after write enable rises, the address, the byte strobes and the driven data are kept unchanged. A write keeps `ready_o` low for TA+DAT+1 cycles.
- R8: Output enable goes low only during reads. The controller never drives the bus while the memory may be driving it.
- R9: Counts: ACC = ceil(access/clk), PW = ceil(pulse/clk), SU = ceil(setup/clk), TA = ceil(turnoff/clk), DAT = max(SU, PW-TA), each at least 1. For grades 7/8/10/12 ns the times in ns are: access = grade; pulse 5/5.5/7/8; setup 3.5/4/5/6; turnoff 3/3.5/4/5.
- R10: The whole 17-bit address range can be reached, and the two extreme addresses do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request |
| ready_o | output | 1 | Idle, a request is taken |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Write lane mask, bit 0 = bits 7:0 |
| rvalid_o | output | 1 | Read data valid pulse |
| rdata_o | output | 16 | Read data |
| mem_addr_o | output | 17 | Memory address |
| mem_ce_no | output | 1 | Chip select, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_lb_no | output | 1 | Lower lane strobe, active low |
| mem_ub_no | output | 1 | Upper lane strobe, active low |
| mem_dq_o | output | 16 | Data bus value driven out |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data bus value read in |

## Verification
The assertions assume that the memory obeys the timing the parameters describe. They also assume that the memory answers with valid data once ACC cycles of stable address have passed, and that it releases the bus within TA cycles of output enable or write enable changing. The bench memory model is built to exactly those limits. It returns a garbage pattern until the access count is reached, and it keeps driving the bus for TA cycles after a read ends, so a phase that is one cycle short shows up as wrong data or as contention. Requests are driven only between edges and only when ready is seen high, except for the deliberate requests sent while busy.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TA,
    ST_DAT,
    ST_HOLD
  } phase_e;

  // round up, never below one cycle
  function automatic int cyc_of(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int t_access_ps(input int grade_ns);
    case (grade_ns)
      7:       return 7000;
      8:       return 8000;
      10:      return 10000;
      default: return 12000;
    endcase
  endfunction

  function automatic int t_pulse_ps(input int grade_ns);
    case (grade_ns)
      7:       return 5000;
      8:       return 5500;
      10:      return 7000;
      default: return 8000;
    endcase
  endfunction

  function automatic int t_setup_ps(input int grade_ns);
    case (grade_ns)
      7:       return 3500;
      8:       return 4000;
      10:      return 5000;
      default: return 6000;
    endcase
  endfunction

  function automatic int t_off_ps(input int grade_ns);
    case (grade_ns)
      7:       return 3000;
      8:       return 3500;
      10:      return 4000;
      default: return 5000;
    endcase
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ACC_CYC = 1,
  parameter int TA_CYC  = 1,
  parameter int DAT_CYC = 1,
  parameter int CW      = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          done_i,
  output phase_e        state_o,
  output phase_e        state_d_o,
  output logic          accept_o,
  output logic          capture_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o
);

  localparam logic [CW-1:0] AccLd = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] TaLd  = CW'(TA_CYC - 1);
  localparam logic [CW-1:0] DatLd = CW'(DAT_CYC - 1);

  phase_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    load_o     = 1'b0;
    load_val_o = '0;
    case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          accept_o = 1'b1;
          load_o   = 1'b1;
          if (we_i) begin
            state_d    = ST_TA;
            load_val_o = TaLd;
          end else begin
            state_d    = ST_RD;
            load_val_o = AccLd;
          end
        end
      end
      ST_RD: begin
        if (done_i) begin
          state_d   = ST_IDLE;
          capture_o = 1'b1;
        end
      end
      ST_TA: begin
        if (done_i) begin
          state_d    = ST_DAT;
          load_o     = 1'b1;
          load_val_o = DatLd;
        end
      end
      ST_DAT: begin
        if (done_i) state_d = ST_HOLD;
      end
      ST_HOLD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign state_d_o = state_d;

endmodule

// File: rtl/sram_pins.sv
module sram_pins
  import sram_ctrl_pkg::*;
#(
  parameter int AW    = 17,
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           state_d_i,
  input  logic             accept_i,
  input  logic             capture_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LANES-1:0] be_i,
  input  logic [DW-1:0]    mem_dq_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_ce_no,
  output logic             mem_oe_no,
  output logic             mem_we_no,
  output logic [LANES-1:0] mem_lane_no,
  output logic [DW-1:0]    mem_dq_o,
  output logic             mem_dq_oe_o,
  output logic             rvalid_o,
  output logic [DW-1:0]    rdata_o
);

  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    dq_q;
  logic [LANES-1:0] be_q;
  logic [LANES-1:0] be_sel;
  logic             ce_q, oe_q, we_q, dqoe_q, rvalid_q;
  logic [DW-1:0]    rdata_q;
  logic             nx_rd, nx_wr, nx_wlow, nx_drv;

  assign nx_rd   = (state_d_i == ST_RD);
  assign nx_wlow = (state_d_i == ST_TA) || (state_d_i == ST_DAT);
  assign nx_wr   = nx_wlow || (state_d_i == ST_HOLD);
  assign nx_drv  = (state_d_i == ST_DAT) || (state_d_i == ST_HOLD);
  assign be_sel  = accept_i ? be_i : be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      dq_q     <= '0;
      be_q     <= '0;
      ce_q     <= 1'b1;
      oe_q     <= 1'b1;
      we_q     <= 1'b1;
      dqoe_q   <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (accept_i) begin
        addr_q <= addr_i;
        dq_q   <= wdata_i;
        be_q   <= be_i;
      end
      ce_q     <= (state_d_i == ST_IDLE);
      oe_q     <= !nx_rd;
      we_q     <= !nx_wlow;
      dqoe_q   <= nx_drv;
      rvalid_q <= capture_i;
      if (capture_i) rdata_q <= mem_dq_i;
    end
  end

  // one strobe per byte lane: reads open every lane, writes follow the mask
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_nq;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_nq <= 1'b1;
      else         lane_nq <= !(nx_rd || (nx_wr && be_sel[l]));
    end
    assign mem_lane_no[l] = lane_nq;
  end

  assign mem_addr_o  = addr_q;
  assign mem_ce_no   = ce_q;
  assign mem_oe_no   = oe_q;
  assign mem_we_no   = we_q;
  assign mem_dq_o    = dq_q;
  assign mem_dq_oe_o = dqoe_q;
  assign rvalid_o    = rvalid_q;
  assign rdata_o     = rdata_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW       = 17,
  parameter int DW       = 16,
  parameter int CLK_PS   = 20000,
  parameter int GRADE_NS = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  output logic          ready_o,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    be_i,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  output logic          mem_lb_no,
  output logic          mem_ub_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int ACC_CYC = cyc_of(t_access_ps(GRADE_NS), CLK_PS);
  localparam int PW_CYC  = cyc_of(t_pulse_ps(GRADE_NS), CLK_PS);
  localparam int SU_CYC  = cyc_of(t_setup_ps(GRADE_NS), CLK_PS);
  localparam int TA_CYC  = cyc_of(t_off_ps(GRADE_NS), CLK_PS);
  localparam int DAT_CYC = (SU_CYC > PW_CYC - TA_CYC) ? SU_CYC : PW_CYC - TA_CYC;
  localparam int MAX1    = (ACC_CYC > TA_CYC) ? ACC_CYC : TA_CYC;
  localparam int CNT_MAX = (MAX1 > DAT_CYC) ? MAX1 : DAT_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);

  phase_e        state_q, state_d;
  logic          accept, capture, load, done;
  logic [CW-1:0] load_val;
  logic [1:0]    lane_n;
  logic [7:0]    ta_lim;

  assign ta_lim = 8'(TA_CYC);

  sram_seq #(
    .ACC_CYC(ACC_CYC),
    .TA_CYC (TA_CYC),
    .DAT_CYC(DAT_CYC),
    .CW     (CW)
  ) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .done_i    (done),
    .state_o   (state_q),
    .state_d_o (state_d),
    .accept_o  (accept),
    .capture_o (capture),
    .load_o    (load),
    .load_val_o(load_val)
  );

  sram_phase_cnt #(.CW(CW)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .done_o    (done)
  );

  sram_pins #(.AW(AW), .DW(DW), .LANES(2)) i_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_d_i  (state_d),
    .accept_i   (accept),
    .capture_i  (capture),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .be_i       (be_i),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_ce_no  (mem_ce_no),
    .mem_oe_no  (mem_oe_no),
    .mem_we_no  (mem_we_no),
    .mem_lane_no(lane_n),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o),
    .rvalid_o   (rvalid_o),
    .rdata_o    (rdata_o)
  );

  assign mem_lb_no = lane_n[0];
  assign mem_ub_no = lane_n[1];
  assign ready_o   = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW = 17,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready_o,
  input logic          rvalid_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ce_no,
  input logic          mem_oe_no,
  input logic          mem_we_no,
  input logic          mem_lb_no,
  input logic          mem_ub_no,
  input logic [DW-1:0] mem_dq_o,
  input logic          mem_dq_oe_o,
  input logic [7:0]    ta_lim_i
);

  logic [7:0] wlow_q;

  // earlier consecutive cycles with write enable low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          wlow_q <= '0;
    else if (mem_we_no)                   wlow_q <= '0;
    else if (wlow_q != 8'hff)             wlow_q <= wlow_q + 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_no |-> (mem_oe_no && mem_we_no && mem_lb_no && mem_ub_no && !mem_dq_oe_o && ready_o));

  assert_busy_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(!ready_o)) |-> $stable(mem_addr_o));

  assert_rvalid_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  assert_turnaround_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && (wlow_q < ta_lim_i)) |-> !mem_dq_oe_o);

  assert_write_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_we_no) && !mem_ce_no) |->
      ($stable(mem_addr_o) && $stable(mem_dq_o) && mem_dq_oe_o &&
       $stable(mem_lb_no) && $stable(mem_ub_no)));

  assert_oe_read_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (mem_we_no && !mem_dq_oe_o && !mem_ce_no));

endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_o    (ready_o),
  .rvalid_o   (rvalid_o),
  .mem_addr_o (mem_addr_o),
  .mem_ce_no  (mem_ce_no),
  .mem_oe_no  (mem_oe_no),
  .mem_we_no  (mem_we_no),
  .mem_lb_no  (mem_lb_no),
  .mem_ub_no  (mem_ub_no),
  .mem_dq_o   (mem_dq_o),
  .mem_dq_oe_o(mem_dq_oe_o),
  .ta_lim_i   (ta_lim)
);

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;

  localparam int CLK_PS = 2500;   // notional period used for the phase counts
  localparam int GRADE  = 10;

  function automatic int up(input int t);
    int c;
    c = (t + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  // grade 10 ns: access 10, pulse 7, setup 5, turnoff 4 (R9)
  localparam int E_ACC = up(10000);
  localparam int E_PW  = up(7000);
  localparam int E_SU  = up(5000);
  localparam int E_TA  = up(4000);
  localparam int E_DAT = (E_SU > E_PW - E_TA) ? E_SU : E_PW - E_TA;
  localparam int E_WRB = E_TA + E_DAT + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic ready, rvalid, ce_n, oe_n, we_n, lb_n, ub_n, dq_oe;
  logic [15:0] rdata, dq_out;
  logic [15:0] dq_in = '0;
  logic [16:0] m_addr;

  always #10 clk = ~clk;  // 50 MHz

  sram_ctrl #(.CLK_PS(CLK_PS), .GRADE_NS(GRADE)) i_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .be_i(be), .rvalid_o(rvalid), .rdata_o(rdata),
    .mem_addr_o(m_addr), .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_lb_no(lb_n), .mem_ub_no(ub_n), .mem_dq_o(dq_out), .mem_dq_oe_o(dq_oe),
    .mem_dq_i(dq_in)
  );

  int total = 0, bad = 0, commits = 0;
  bit finished = 0;
  logic [15:0] mdl [int];
  logic [15:0] shadow [int];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_mdl(input int a);
    return mdl.exists(a) ? mdl[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] rd_sh(input int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] n,
                                        input logic [1:0] m);
    return {m[1] ? n[15:8] : o[15:8], m[0] ? n[7:0] : o[7:0]};
  endfunction

  // behavioural memory with cycle-level timing checks
  bit rd_act, wr_act, p_rd, p_wr, drv;
  int acc_cnt, linger, wlow, dstab;
  logic [16:0] p_addr, s_addr;
  logic p_lb, p_ub, s_lb, s_ub;
  logic [15:0] p_dq, s_dq, word;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_rd = 0; p_wr = 0; acc_cnt = 0; linger = 0; wlow = 0; dstab = 0; dq_in = '0;
    end else begin
      rd_act = !ce_n && we_n && !oe_n;
      wr_act = !ce_n && !we_n;
      if (rd_act) begin
        if (p_rd && m_addr == p_addr && lb_n == p_lb && ub_n == p_ub) acc_cnt++;
        else acc_cnt = 1;
        linger = E_TA;
        drv = 1;
      end else if (linger > 0) begin
        drv = 1; linger--; acc_cnt = 0;
      end else begin
        drv = 0; acc_cnt = 0;
      end
      word = rd_mdl(int'(m_addr));
      if (rd_act && acc_cnt >= E_ACC)
        dq_in = {ub_n ? 8'h00 : word[15:8], lb_n ? 8'h00 : word[7:0]};
      else if (drv) dq_in = 16'hA5A5;
      else dq_in = 16'h0000;
      if (drv && dq_oe) chk(0, "R8/R6", "bus driven by both sides", 1, 0);
      if (!oe_n && !we_n) chk(0, "R8", "output enable low during write", 0, 1);
      if (wr_act) begin
        if (p_wr && m_addr != p_addr) chk(0, "R4", "address moved in write", m_addr, p_addr);
        wlow++;
        if (dq_oe) dstab = (dstab > 0 && dq_out == p_dq) ? dstab + 1 : 1;
        else dstab = 0;
        s_addr = m_addr; s_lb = lb_n; s_ub = ub_n; s_dq = dq_out;
      end else if (p_wr) begin
        chk(wlow >= E_PW, "R4", "write pulse cycles", wlow, E_PW);
        chk(dstab >= E_SU, "R5", "data setup cycles", dstab, E_SU);
        chk(dq_oe && dq_out == s_dq && m_addr == s_addr && lb_n == s_lb && ub_n == s_ub,
            "R7", "hold after write enable rises", {dq_oe, dq_out}, {1'b1, s_dq});
        word = rd_mdl(int'(s_addr));
        if (!s_lb) word[7:0] = s_dq[7:0];
        if (!s_ub) word[15:8] = s_dq[15:8];
        mdl[int'(s_addr)] = word;
        commits++;
        wlow = 0; dstab = 0;
      end
      p_rd = rd_act; p_wr = wr_act; p_addr = m_addr; p_lb = lb_n; p_ub = ub_n; p_dq = dq_out;
    end
  end

  task automatic op(input bit w, input logic [16:0] a, input logic [15:0] d,
                    input logic [1:0] m, input bit inj);
    int n;
    int c0;
    bit early;
    logic [15:0] exp;
    c0 = commits;
    early = 0;
    while (!ready) @(negedge clk);
    req = 1; we = w; addr = a; wdata = d; be = m;
    @(negedge clk);
    req = 0;
    n = 0;
    while (!ready) begin
      n++;
      if (rvalid) early = 1;
      if (inj && n == 1) begin
        req = 1; we = 0; addr = a ^ 17'h1; wdata = ~d; be = 2'b11;
      end
      if (inj && n == 2) req = 0;
      @(negedge clk);
    end
    if (w) begin
      shadow[int'(a)] = merge(rd_sh(int'(a)), d, m);
      chk(n == E_WRB, "R7/R9", "write busy cycles", n, E_WRB);
      chk(commits == c0 + 1 && !rvalid && !early, "R2/R4", "one memory write per request",
          commits - c0, 1);
    end else begin
      exp = rd_sh(int'(a));
      chk(n == E_ACC, "R3/R9", "read latency cycles", n, E_ACC);
      chk(rvalid && !early, "R3", "read valid pulse", rvalid, 1);
      chk(rdata == exp, "R3", "read data", rdata, exp);
    end
  endtask

  task automatic idle_check(input string rq);
    chk(ce_n && oe_n && we_n && lb_n && ub_n && !dq_oe && ready && !rvalid, rq,
        "idle pin state", {ce_n, oe_n, we_n, lb_n, ub_n, dq_oe, ready, rvalid}, 8'b11111010);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    idle_check("R1");
    rst_n = 1;
    @(negedge clk);
    idle_check("R1");

    op(1, 17'h00000, 16'h1234, 2'b11, 0);
    op(0, 17'h00000, 16'h0000, 2'b00, 0);
    op(1, 17'h00000, 16'hABCD, 2'b01, 0);   // lower lane only (R4)
    op(0, 17'h00000, 16'h0000, 2'b00, 0);
    op(1, 17'h00000, 16'h5678, 2'b10, 0);   // upper lane only (R4)
    op(0, 17'h00000, 16'h0000, 2'b00, 0);
    op(1, 17'h00000, 16'hFFFF, 2'b00, 0);   // no lane (R4)
    op(0, 17'h00000, 16'h0000, 2'b00, 0);
    chk(rdata == 16'h56CD, "R4", "masked bytes kept", rdata, 16'h56CD);
    op(1, 17'h1FFFF, 16'hBEEF, 2'b11, 0);   // top of range (R10)
    op(0, 17'h1FFFF, 16'h0000, 2'b00, 0);
    op(0, 17'h00000, 16'h0000, 2'b00, 0);
    chk(rdata == 16'h56CD, "R10", "extreme addresses do not alias", rdata, 16'h56CD);
    op(1, 17'h00005, 16'h0F0F, 2'b11, 1);   // request while busy (R2)
    op(0, 17'h00004, 16'h0000, 2'b00, 1);
    op(0, 17'h00005, 16'h0000, 2'b00, 0);
    @(negedge clk);
    idle_check("R1");

    for (int i = 0; i < 150; i++) begin
      logic [16:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel == 9) ? 17'h1FFFF : (sel == 8) ? 17'h1FFFE : 17'($urandom_range(0, 7));
      op(1'($urandom_range(0, 1)), a, 16'($urandom), 2'($urandom_range(0, 3)),
         ($urandom_range(0, 7) == 0));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule